// File: doc/BRIEF.md
# Packet buffer memory manager

This block keeps the books for the packet buffer of a network controller. It does not hold packet data. It records which 256-byte pages belong to which packet number, hands out packet numbers on request, and orders packet numbers in three queues. The receive queue is filled by the MAC and drained by the host. The transmit queue is filled by the host and drained by the MAC. The transmit-completion queue is filled by the MAC and drained by the host.

The host controls the block with a 3-bit opcode and a size field N. Together they form a command byte: the opcode sits in bits [7:5] and N in bits [2:0]. The host also writes a packet number register that several commands read. An allocation claims N+1 pages and the lowest free packet number, and the result appears at once in the allocation result register. A release walks the whole page table, one page per clock, and the busy flag stays high while the walk runs. The byte read back at the command address carries busy in bit 0, which is the bit position N0 takes on a write.

Top module: `pktbuf_mgr`

## Requirements
- R1: The block accepts a command only when `cmd_we` is high and `busy` is low. `cmd_rdbk` reads back as {last accepted opcode in bits [7:5], zeros in bits [4:1], busy in bit 0}. Opcode 0 changes no state other than the recorded last opcode.
- R2: Opcode 1 with size field N claims the lowest-numbered free packet number and the N+1 lowest-indexed free pages. On the next clock `alloc_res` = {1'b0, packet number}.
- R3: If fewer than N+1 pages are free, or no packet number is free, an allocation changes no ownership and `alloc_res` becomes {1'b1, 4'b0000}. Bit 4 is the failure flag.
- R4: When `alloc_int_en` is high, a successful allocation sets `alloc_int`. Every accepted allocation first clears `alloc_int`, and opcode 2 clears it as well.
- R5: Opcode 2 frees every page and packet number, empties all three queues, clears `alloc_int` and sets `alloc_res` to {1'b1, 4'b0000}.
- R6: Opcode 3 removes the head of the receive queue and frees nothing, so the next entry appears at `rx_head`.
- R7: Opcode 4 on a non-empty receive queue removes the head and frees all pages of that packet and its number. `busy` is high for exactly 32 clocks after the accepting edge. On an empty receive queue the command does nothing.
- R8: Opcode 5 frees all pages and the number of the packet held in the packet number register (`pnr`). It raises `busy` for exactly 32 clocks.
- R9: A command written while `busy` is high is ignored: `alloc_res` and the last recorded opcode do not change.
- R10: Opcode 6 appends `pnr` to the transmit queue. `tx_pop` removes the transmit head, and `txc_pop` removes the completion head.
- R11: Opcode 7 empties the transmit queue and the completion queue. It leaves the receive queue and all page ownership untouched.
- R12: Each queue is first-in first-out and holds 16 entries, with `*_full` and `*_empty` flags. A push while full is dropped, and a pop while empty is ignored.
- R13: `rx_int` is high exactly when the receive queue is not empty.
- R14: After hardware reset, `busy` and `alloc_int` are low, all queues are empty, `cmd_rdbk` is 0 and `alloc_res` is {1'b1, 4'b0000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command opcode (command byte bits [7:5]) |
| cmd_size | input | 3 | Size field N (command byte bits [2:0]) |
| cmd_rdbk | output | 8 | Command byte read back: last opcode, busy in bit 0 |
| pnr_we | input | 1 | Packet number register write strobe |
| pnr_wdata | input | 4 | Packet number register write data |
| pnr | output | 4 | Packet number register |
| alloc_int_en | input | 1 | Enables the allocation interrupt |
| alloc_res | output | 5 | Allocation result: failure flag and packet number |
| alloc_int | output | 1 | Allocation success interrupt |
| busy | output | 1 | Page release in progress |
| rx_push | input | 1 | MAC pushes a received packet number |
| rx_push_pkt | input | 4 | Packet number to push to the receive queue |
| rx_head | output | 4 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_int | output | 1 | Receive interrupt |
| tx_pop | input | 1 | MAC takes the transmit queue head |
| tx_head | output | 4 | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| txc_push | input | 1 | MAC pushes a completed packet number |
| txc_push_pkt | input | 4 | Packet number to push to the completion queue |
| txc_pop | input | 1 | Host takes the completion queue head |
| txc_head | output | 4 | Completion queue head |
| txc_empty | output | 1 | Completion queue empty |
| txc_full | output | 1 | Completion queue full |

## Verification
The bench fills the page pool exactly and then asks for one more page, which catches an off-by-one in the N+1 page count: such a design would either refuse the last legal allocation or grant a page it does not have. It frees a packet in the middle of the pool and checks that the next allocation gets that lowest number back, and it counts the busy window edge by edge, so a release walk one clock short or long shows up. It removes a receive head without release and checks that the packet's number stays taken, which catches a design that frees on the plain remove. It also checks that a transmit flush keeps the receive queue and page ownership, that a command sent while busy leaves the result register as it was, and that a push into a full queue is dropped rather than wrapping over the oldest entry.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_ALLOC      = 3'd1,
        OP_RESET      = 3'd2,
        OP_RX_POP     = 3'd3,
        OP_RX_POPFREE = 3'd4,
        OP_FREE_PNR   = 3'd5,
        OP_TX_PUSH    = 3'd6,
        OP_TX_FLUSH   = 3'd7
    } op_e;

endpackage

// File: rtl/pktbuf_queue.sv
module pktbuf_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    // DEPTH is a power of two so that the pointers wrap on their own.
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           count;
    } q_state_t;

    q_state_t q_q, q_d;
    logic do_push, do_pop;

    always_comb begin
        q_d     = q_q;
        do_push = push && (q_q.count != CW'(DEPTH));
        do_pop  = pop && (q_q.count != '0);
        if (do_push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = q_q.wr + AW'(1);
        end
        if (do_pop) begin
            q_d.rd = q_q.rd + AW'(1);
        end
        q_d.count = q_q.count + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            q_d.rd    = '0;
            q_d.wr    = '0;
            q_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rd];
    assign empty = (q_q.count == '0);
    assign full  = (q_q.count == CW'(DEPTH));

endmodule

// File: rtl/pktbuf_pages.sv
module pktbuf_pages #(
    parameter int NUM_PKT  = 16,
    parameter int NUM_PAGE = 32,
    parameter int SZW      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       alloc_req,
    input  logic [SZW-1:0]             alloc_n,
    input  logic                       free_req,
    input  logic [$clog2(NUM_PKT)-1:0] free_pkt,
    output logic                       alloc_ok,
    output logic [$clog2(NUM_PKT)-1:0] alloc_pkt,
    output logic                       busy
);
    localparam int PNW = $clog2(NUM_PKT);
    localparam int PGW = $clog2(NUM_PAGE);

    typedef struct packed {
        logic [NUM_PKT-1:0]            pkt_used;
        logic [NUM_PAGE-1:0]           page_vld;
        logic [NUM_PAGE-1:0][PNW-1:0]  page_own;
        logic                          busy;
        logic [PGW-1:0]                idx;
        logic [PNW-1:0]                fpkt;
    } pg_state_t;

    pg_state_t pg_q, pg_d;
    int        free_cnt;
    int        need;
    int        taken;
    logic      pick_found;
    logic [PNW-1:0] pick;

    // Free-page count and lowest free packet number, both from current state.
    always_comb begin
        free_cnt = 0;
        for (int p = 0; p < NUM_PAGE; p++) begin
            if (!pg_q.page_vld[p]) free_cnt = free_cnt + 1;
        end
        pick_found = 1'b0;
        pick       = '0;
        for (int i = 0; i < NUM_PKT; i++) begin
            if (!pick_found && !pg_q.pkt_used[i]) begin
                pick_found = 1'b1;
                pick       = PNW'(i);
            end
        end
        need     = int'(alloc_n) + 1;
        alloc_ok = pick_found && (free_cnt >= need);
    end

    always_comb begin
        pg_d  = pg_q;
        taken = 0;
        if (clr) begin
            pg_d = '0;
        end else if (pg_q.busy) begin
            // One page of the release walk per clock.
            if (pg_q.page_vld[pg_q.idx] && (pg_q.page_own[pg_q.idx] == pg_q.fpkt)) begin
                pg_d.page_vld[pg_q.idx] = 1'b0;
            end
            if (pg_q.idx == PGW'(NUM_PAGE - 1)) begin
                pg_d.busy               = 1'b0;
                pg_d.pkt_used[pg_q.fpkt] = 1'b0;
            end else begin
                pg_d.idx = pg_q.idx + PGW'(1);
            end
        end else if (alloc_req && alloc_ok) begin
            pg_d.pkt_used[pick] = 1'b1;
            for (int p = 0; p < NUM_PAGE; p++) begin
                if (!pg_q.page_vld[p] && (taken < need)) begin
                    pg_d.page_vld[p] = 1'b1;
                    pg_d.page_own[p] = pick;
                    taken            = taken + 1;
                end
            end
        end else if (free_req) begin
            pg_d.busy = 1'b1;
            pg_d.idx  = '0;
            pg_d.fpkt = free_pkt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign alloc_pkt = pick;
    assign busy      = pg_q.busy;

endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr #(
    parameter int NUM_PKT  = 16,
    parameter int NUM_PAGE = 32,
    parameter int QDEPTH   = 16,
    parameter int SZW      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic [2:0]                 cmd_op,
    input  logic [SZW-1:0]             cmd_size,
    output logic [7:0]                 cmd_rdbk,
    input  logic                       pnr_we,
    input  logic [$clog2(NUM_PKT)-1:0] pnr_wdata,
    output logic [$clog2(NUM_PKT)-1:0] pnr,
    input  logic                       alloc_int_en,
    output logic [$clog2(NUM_PKT):0]   alloc_res,
    output logic                       alloc_int,
    output logic                       busy,
    input  logic                       rx_push,
    input  logic [$clog2(NUM_PKT)-1:0] rx_push_pkt,
    output logic [$clog2(NUM_PKT)-1:0] rx_head,
    output logic                       rx_empty,
    output logic                       rx_full,
    output logic                       rx_int,
    input  logic                       tx_pop,
    output logic [$clog2(NUM_PKT)-1:0] tx_head,
    output logic                       tx_empty,
    output logic                       tx_full,
    input  logic                       txc_push,
    input  logic [$clog2(NUM_PKT)-1:0] txc_push_pkt,
    input  logic                       txc_pop,
    output logic [$clog2(NUM_PKT)-1:0] txc_head,
    output logic                       txc_empty,
    output logic                       txc_full
);
    import pktbuf_pkg::*;

    localparam int PNW  = $clog2(NUM_PKT);
    localparam int RESW = PNW + 1;
    localparam logic [RESW-1:0] RES_FAIL = {1'b1, {PNW{1'b0}}};

    typedef struct packed {
        logic [PNW-1:0]  pnr;
        logic [RESW-1:0] res;
        logic            alloc_int;
        logic [2:0]      last_op;
    } ctl_state_t;

    ctl_state_t ctl_q, ctl_d;

    logic           accept;
    op_e            op;
    logic           pg_clr, pg_alloc, pg_free, pg_ok, pg_busy;
    logic [PNW-1:0] pg_pick, pg_free_pkt;
    logic           rx_pop_c, tx_push_c, q_flush_all, tx_flush_c;

    always_comb begin
        ctl_d       = ctl_q;
        accept      = cmd_we && !pg_busy;
        op          = op_e'(cmd_op);
        pg_clr      = 1'b0;
        pg_alloc    = 1'b0;
        pg_free     = 1'b0;
        pg_free_pkt = ctl_q.pnr;
        rx_pop_c    = 1'b0;
        tx_push_c   = 1'b0;
        q_flush_all = 1'b0;
        tx_flush_c  = 1'b0;
        if (pnr_we) ctl_d.pnr = pnr_wdata;
        if (accept) begin
            ctl_d.last_op = cmd_op;
            case (op)
                OP_ALLOC: begin
                    pg_alloc        = 1'b1;
                    ctl_d.alloc_int = 1'b0;
                    if (pg_ok) begin
                        ctl_d.res = {1'b0, pg_pick};
                        if (alloc_int_en) ctl_d.alloc_int = 1'b1;
                    end else begin
                        ctl_d.res = RES_FAIL;
                    end
                end
                OP_RESET: begin
                    pg_clr          = 1'b1;
                    q_flush_all     = 1'b1;
                    ctl_d.res       = RES_FAIL;
                    ctl_d.alloc_int = 1'b0;
                end
                OP_RX_POP: rx_pop_c = 1'b1;
                OP_RX_POPFREE: begin
                    if (!rx_empty) begin
                        rx_pop_c    = 1'b1;
                        pg_free     = 1'b1;
                        pg_free_pkt = rx_head;
                    end
                end
                OP_FREE_PNR: pg_free = 1'b1;
                OP_TX_PUSH:  tx_push_c = 1'b1;
                OP_TX_FLUSH: tx_flush_c = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.res       <= RES_FAIL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pktbuf_pages #(
        .NUM_PKT  (NUM_PKT),
        .NUM_PAGE (NUM_PAGE),
        .SZW      (SZW)
    ) u_pages (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pg_clr),
        .alloc_req (pg_alloc),
        .alloc_n   (cmd_size),
        .free_req  (pg_free),
        .free_pkt  (pg_free_pkt),
        .alloc_ok  (pg_ok),
        .alloc_pkt (pg_pick),
        .busy      (pg_busy)
    );

    pktbuf_queue #(.DEPTH(QDEPTH), .W(PNW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush_all),
        .push      (rx_push),
        .push_data (rx_push_pkt),
        .pop       (rx_pop_c),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    pktbuf_queue #(.DEPTH(QDEPTH), .W(PNW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush_all || tx_flush_c),
        .push      (tx_push_c),
        .push_data (ctl_q.pnr),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    pktbuf_queue #(.DEPTH(QDEPTH), .W(PNW)) u_txcq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush_all || tx_flush_c),
        .push      (txc_push),
        .push_data (txc_push_pkt),
        .pop       (txc_pop),
        .head      (txc_head),
        .empty     (txc_empty),
        .full      (txc_full)
    );

    assign busy      = pg_busy;
    assign pnr       = ctl_q.pnr;
    assign alloc_res = ctl_q.res;
    assign alloc_int = ctl_q.alloc_int;
    assign rx_int    = !rx_empty;
    assign cmd_rdbk  = {ctl_q.last_op, 4'b0000, pg_busy};

endmodule

// File: rtl/pktbuf_mgr_chk.sv
module pktbuf_mgr_chk #(
    parameter int PNW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_we,
    input logic [2:0]     cmd_op,
    input logic [7:0]     cmd_rdbk,
    input logic           alloc_int_en,
    input logic [PNW:0]   alloc_res,
    input logic           alloc_int,
    input logic           busy,
    input logic           rx_empty,
    input logic           tx_empty,
    input logic           txc_empty
);
    logic acc;
    assign acc = cmd_we && !busy;

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy) |=> ($stable(alloc_res) && $stable(cmd_rdbk[7:5]))); // R9

    AST_FAIL_NO_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_res[PNW] |-> (alloc_res[PNW-1:0] == '0)); // R3

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd2) |=> (rx_empty && tx_empty && txc_empty && !alloc_int)); // R5

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd7) |=> (tx_empty && txc_empty)); // R11

    AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd5) |=> busy); // R8

    AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd0) |=> ($stable(alloc_res) && $stable(alloc_int))); // R1

    AST_ALLOC_INT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1 && !alloc_int_en) |=> !alloc_int); // R4

endmodule

bind pktbuf_mgr pktbuf_mgr_chk #(.PNW(PNW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_op       (cmd_op),
    .cmd_rdbk     (cmd_rdbk),
    .alloc_int_en (alloc_int_en),
    .alloc_res    (alloc_res),
    .alloc_int    (alloc_int),
    .busy         (busy),
    .rx_empty     (rx_empty),
    .tx_empty     (tx_empty),
    .txc_empty    (txc_empty)
);

// File: tb/pktbuf_mgr_bench.sv
`timescale 1ns/1ps
module pktbuf_mgr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [2:0] cmd_size = '0;
    logic [7:0] cmd_rdbk;
    logic       pnr_we = 1'b0;
    logic [3:0] pnr_wdata = '0;
    logic [3:0] pnr;
    logic       alloc_int_en = 1'b0;
    logic [4:0] alloc_res;
    logic       alloc_int, busy;
    logic       rx_push = 1'b0;
    logic [3:0] rx_push_pkt = '0;
    logic [3:0] rx_head;
    logic       rx_empty, rx_full, rx_int;
    logic       tx_pop = 1'b0;
    logic [3:0] tx_head;
    logic       tx_empty, tx_full;
    logic       txc_push = 1'b0;
    logic [3:0] txc_push_pkt = '0;
    logic       txc_pop = 1'b0;
    logic [3:0] txc_head;
    logic       txc_empty, txc_full;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pktbuf_mgr u_pktbuf_mgr (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_rdbk(cmd_rdbk),
        .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .pnr(pnr),
        .alloc_int_en(alloc_int_en), .alloc_res(alloc_res), .alloc_int(alloc_int), .busy(busy),
        .rx_push(rx_push), .rx_push_pkt(rx_push_pkt), .rx_head(rx_head),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_int(rx_int),
        .tx_pop(tx_pop), .tx_head(tx_head), .tx_empty(tx_empty), .tx_full(tx_full),
        .txc_push(txc_push), .txc_push_pkt(txc_push_pkt), .txc_pop(txc_pop),
        .txc_head(txc_head), .txc_empty(txc_empty), .txc_full(txc_full)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] n);
        cmd_we   = 1'b1;
        cmd_op   = op;
        cmd_size = n;
        tick();
        cmd_we   = 1'b0;
    endtask

    task automatic set_pnr(input logic [3:0] v);
        pnr_we    = 1'b1;
        pnr_wdata = v;
        tick();
        pnr_we    = 1'b0;
    endtask

    task automatic push_rx(input logic [3:0] v);
        rx_push     = 1'b1;
        rx_push_pkt = v;
        tick();
        rx_push     = 1'b0;
    endtask

    task automatic push_txc(input logic [3:0] v);
        txc_push     = 1'b1;
        txc_push_pkt = v;
        tick();
        txc_push     = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) tick();
    endtask

    task automatic t_reset_state();
        chk("R14 busy", busy, 0);
        chk("R14 alloc_int", alloc_int, 0);
        chk("R14 rx_empty", rx_empty, 1);
        chk("R14 tx_empty", tx_empty, 1);
        chk("R14 txc_empty", txc_empty, 1);
        chk("R14 rdbk", cmd_rdbk, 8'h00);
        chk("R14 alloc_res", alloc_res, 5'h10);
        chk("R13 rx_int idle", rx_int, 0);
    endtask

    task automatic t_alloc_basic();
        alloc_int_en = 1'b1;
        cmd(3'd1, 3'd0);
        chk("R2 first pkt", alloc_res, 5'h00);
        chk("R4 int set", alloc_int, 1);
        chk("R1 rdbk op", cmd_rdbk, 8'h20);
        cmd(3'd1, 3'd1);
        chk("R2 second pkt", alloc_res, 5'h01);
        cmd(3'd1, 3'd2);
        chk("R2 third pkt", alloc_res, 5'h02);
        alloc_int_en = 1'b0;
        cmd(3'd1, 3'd0);
        chk("R2 fourth pkt", alloc_res, 5'h03);
        chk("R4 int cleared", alloc_int, 0);
        cmd(3'd0, 3'd5);
        chk("R1 nop result", alloc_res, 5'h03);
        chk("R1 nop rdbk", cmd_rdbk, 8'h00);
    endtask

    task automatic t_pool_and_release();
        cmd(3'd2, 3'd0);
        chk("R5 result after reset cmd", alloc_res, 5'h10);
        for (int i = 0; i < 4; i++) begin
            cmd(3'd1, 3'd7);
            chk("R2 eight-page alloc", alloc_res, 32'(i));
        end
        cmd(3'd1, 3'd0);
        chk("R3 no pages left", alloc_res, 5'h10);
        set_pnr(4'd2);
        chk("R8 pnr", pnr, 4'd2);
        cmd(3'd5, 3'd0);
        chk("R8 busy after release", busy, 1);
        chk("R1 busy in rdbk bit0", cmd_rdbk, 8'hA1);
        cmd(3'd1, 3'd0);
        chk("R9 ignored result", alloc_res, 5'h10);
        chk("R9 ignored opcode", cmd_rdbk[7:5], 3'd5);
        for (int i = 0; i < 30; i++) tick();
        chk("R8 busy last cycle", busy, 1);
        tick();
        chk("R8 busy dropped", busy, 0);
        cmd(3'd1, 3'd7);
        chk("R2 freed number reused", alloc_res, 5'h02);
        cmd(3'd1, 3'd0);
        chk("R3 full again", alloc_res, 5'h10);
    endtask

    task automatic t_number_exhaust();
        cmd(3'd2, 3'd0);
        for (int i = 0; i < 16; i++) begin
            cmd(3'd1, 3'd0);
            chk("R2 number order", alloc_res, 32'(i));
        end
        cmd(3'd1, 3'd0);
        chk("R3 no number left", alloc_res, 5'h10);
    endtask

    task automatic t_rx_queue();
        cmd(3'd2, 3'd0);
        for (int i = 0; i < 3; i++) cmd(3'd1, 3'd0);
        push_rx(4'd0);
        push_rx(4'd1);
        push_rx(4'd2);
        chk("R13 rx_int set", rx_int, 1);
        chk("R12 rx head", rx_head, 4'd0);
        cmd(3'd3, 3'd0);
        chk("R6 next head", rx_head, 4'd1);
        chk("R6 no busy", busy, 0);
        cmd(3'd4, 3'd0);
        chk("R7 head after pop", rx_head, 4'd2);
        chk("R7 busy", busy, 1);
        for (int i = 0; i < 31; i++) tick();
        chk("R7 busy window", busy, 1);
        tick();
        chk("R7 busy end", busy, 0);
        cmd(3'd1, 3'd0);
        chk("R7 released number reused, R6 kept 0", alloc_res, 5'h01);
        cmd(3'd4, 3'd0);
        wait_idle();
        chk("R13 rx_int clear", rx_int, 0);
        cmd(3'd4, 3'd0);
        chk("R7 empty no busy", busy, 0);
        for (int i = 0; i < 16; i++) push_rx(4'(i));
        chk("R12 full", rx_full, 1);
        push_rx(4'd9);
        for (int i = 0; i < 16; i++) begin
            chk("R12 order", rx_head, 32'(i));
            cmd(3'd3, 3'd0);
        end
        chk("R12 dropped push", rx_empty, 1);
        cmd(3'd3, 3'd0);
        chk("R12 pop empty", rx_empty, 1);
    endtask

    task automatic t_tx_queues();
        cmd(3'd2, 3'd0);
        set_pnr(4'd6);
        cmd(3'd6, 3'd0);
        chk("R10 tx head", tx_head, 4'd6);
        set_pnr(4'd2);
        cmd(3'd6, 3'd0);
        chk("R10 tx head kept", tx_head, 4'd6);
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
        chk("R10 tx after pop", tx_head, 4'd2);
        push_txc(4'd5);
        push_txc(4'd7);
        txc_pop = 1'b1;
        tick();
        txc_pop = 1'b0;
        chk("R10 txc after pop", txc_head, 4'd7);
        push_rx(4'd3);
        for (int i = 0; i < 4; i++) cmd(3'd1, 3'd7);
        cmd(3'd7, 3'd0);
        chk("R11 tx empty", tx_empty, 1);
        chk("R11 txc empty", txc_empty, 1);
        chk("R11 rx kept", rx_head, 4'd3);
        chk("R11 rx not empty", rx_empty, 0);
        cmd(3'd1, 3'd0);
        chk("R11 pages kept", alloc_res, 5'h10);
    endtask

    task automatic t_reset_cmd();
        alloc_int_en = 1'b1;
        cmd(3'd2, 3'd0);
        cmd(3'd1, 3'd3);
        chk("R4 int before reset", alloc_int, 1);
        push_rx(4'd0);
        set_pnr(4'd0);
        cmd(3'd6, 3'd0);
        push_txc(4'd0);
        cmd(3'd2, 3'd0);
        chk("R5 int cleared", alloc_int, 0);
        chk("R5 rx empty", rx_empty, 1);
        chk("R5 tx empty", tx_empty, 1);
        chk("R5 txc empty", txc_empty, 1);
        chk("R5 result", alloc_res, 5'h10);
        alloc_int_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cmd(3'd1, 3'd7);
            chk("R5 pages freed", alloc_res, 32'(i));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_alloc_basic();
        t_pool_and_release();
        t_number_exhaust();
        t_rx_queue();
        t_tx_queues();
        t_reset_cmd();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule